// File: doc/BRIEF.md
# Chained Transmit Descriptor Queue Engine

This block is a single transmit queue controller that walks a linked chain of descriptors kept in memory. Software loads a starting descriptor address once, then issues kick pulses. The engine fetches each descriptor through a request/response read port. It models the transmission of each frame as a fixed number of cycles. For every finished descriptor it reports a one-cycle completion event that carries the descriptor's address and frame length.

When the engine reaches the end of a chain, it stays on the last descriptor it sent instead of forgetting it. The pointer write is honoured only while no pointer is loaded. After that, software extends the chain by writing the link word of the parked descriptor and kicking again. The engine then re-reads the parked descriptor, follows its link, and does not send that descriptor a second time. A stop request clears the queue back to the never-loaded state, so one fresh pointer write becomes possible again.

Top module: `txq_chain_dma`

## Requirements
- R1: After reset, the state reads IDLE_EMPTY (code 0), no pointer is loaded, the held pointer is 0, the write-error flag is clear, and no memory request or completion event is active.
- R2: In IDLE_EMPTY with no pointer loaded, a pointer write of a non-zero address loads it and marks the queue loaded. The next kick starts fetching at that address (state FETCH, code 1). A kick with no pointer loaded does nothing.
- R3: A descriptor is one 64-bit response. Bits 31:0 hold the link address, where 0 means null. Bit 32 is the end-of-list flag. Bits 47:36 hold the frame length. Each descriptor on the chain is fetched once. Its completion event, carrying its address and length, appears XMIT_LAT cycles after its response is accepted (state XMIT, code 2). The engine then follows the link.
- R4: The walk stops in PARKED (code 3) after a descriptor whose link is null or whose end-of-list flag is set. The held pointer then equals the address of that last transmitted descriptor.
- R5: While a pointer is loaded, a pointer write is ignored and the held pointer stays unchanged. The write also sets a sticky write-error flag, which only reset clears.
- R6: A kick while the engine is in FETCH, XMIT or REFETCH has no effect: it causes no extra fetch and no extra completion.
- R7: A kick in PARKED re-fetches the descriptor at the held address (state REFETCH, code 4) without producing a completion for it. If its link is non-null, the walk continues at that link address.
- R8: If the re-fetched link is null, the engine returns to PARKED with no completion, and the held pointer is unchanged.
- R9: A stop request moves the engine to IDLE_EMPTY, clears the loaded flag and the held pointer, and discards any read response still outstanding. A later pointer write is accepted again.
- R10: At most one memory read is outstanding at a time. A request held without ready keeps its valid and its address stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Descriptor pointer write strobe |
| ptr_wdata | input | AW | Descriptor pointer write value |
| kick | input | 1 | Transmit enable pulse |
| stop | input | 1 | Stop request, returns the queue to never-loaded |
| stat_state | output | 3 | Current state code |
| stat_loaded | output | 1 | A pointer is loaded |
| stat_ptr | output | AW | Held descriptor pointer |
| stat_wr_err | output | 1 | Sticky flag: pointer write refused |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Descriptor address to read |
| mem_rsp_valid | input | 1 | Read response valid (single beat) |
| mem_rsp_data | input | 2*AW | Descriptor: word 1 in upper half, link word in lower half |
| done_valid | output | 1 | One-cycle completion event |
| done_addr | output | AW | Address of the completed descriptor |
| done_len | output | 12 | Frame length of the completed descriptor |

## Verification
The bench sweeps response latency, request-ready throttling, chain length, and the kind of chain end (null link or end-of-list flag with a decoy link). It compares the completion log with an arithmetically built chain.

It extends a parked chain and checks two things. First, the parked descriptor is re-read but not re-sent; a design that re-sends it logs a duplicate completion. Second, a null link on re-read leaves the queue parked.

It issues kicks throughout a walk, which would show up as extra fetches in a design that re-entered fetching. It also stops the queue while a response is in flight and then reloads it. A design that kept the stale response would report the new address with the old descriptor's length.

// File: rtl/txq_chain_dma.sv
module txq_chain_dma #(
  parameter int AW       = 32,
  parameter int LENW     = 12,
  parameter int XMIT_LAT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ptr_wr,
  input  logic [AW-1:0]   ptr_wdata,
  input  logic            kick,
  input  logic            stop,
  output logic [2:0]      stat_state,
  output logic            stat_loaded,
  output logic [AW-1:0]   stat_ptr,
  output logic            stat_wr_err,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [2*AW-1:0] mem_rsp_data,
  output logic            done_valid,
  output logic [AW-1:0]   done_addr,
  output logic [LENW-1:0] done_len
);
  localparam int CW      = $clog2(XMIT_LAT + 1);
  localparam int LEN_LSB = AW + 4;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_FETCH = 3'd1, S_XMIT = 3'd2, S_PARK = 3'd3, S_REFETCH = 3'd4
  } st_t;

  st_t            st;
  logic [AW-1:0]  ptr, link_q;
  logic           veol_q, loaded, err, sent, drop;
  logic [LENW-1:0] len_q;
  logic [CW-1:0]  cnt;

  wire [AW-1:0]   link_in = mem_rsp_data[AW-1:0];
  wire            veol_in = mem_rsp_data[AW];
  wire [LENW-1:0] len_in  = mem_rsp_data[LEN_LSB +: LENW];
  wire            unused_rsp = ^{mem_rsp_data[2*AW-1:LEN_LSB+LENW], mem_rsp_data[LEN_LSB-1:AW+1]};

  wire fetching = (st == S_FETCH) || (st == S_REFETCH);
  wire req_hs   = mem_req_valid && mem_req_ready;
  wire rsp_take = mem_rsp_valid && sent;

  assign mem_req_valid = fetching && !sent && !drop;
  assign mem_req_addr  = ptr;
  assign done_valid    = (st == S_XMIT) && (cnt == '0);
  assign done_addr     = ptr;
  assign done_len      = len_q;
  assign stat_state    = st;
  assign stat_loaded   = loaded;
  assign stat_ptr      = ptr;
  assign stat_wr_err   = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; link_q <= '0; veol_q <= 1'b0; len_q <= '0;
      loaded <= 1'b0; err <= 1'b0; sent <= 1'b0; drop <= 1'b0; cnt <= '0;
    end else if (stop) begin
      st     <= S_IDLE;
      ptr    <= '0;
      loaded <= 1'b0;
      sent   <= 1'b0;
      drop   <= ((sent || drop) && !mem_rsp_valid) || req_hs;
    end else begin
      if (drop && mem_rsp_valid) drop <= 1'b0;
      if (ptr_wr) begin
        if (!loaded) begin
          ptr    <= ptr_wdata;
          loaded <= (ptr_wdata != '0);
        end else begin
          err <= 1'b1;
        end
      end
      unique case (st)
        S_IDLE: if (kick && loaded) st <= S_FETCH;
        S_FETCH, S_REFETCH: begin
          if (req_hs) sent <= 1'b1;
          if (rsp_take) begin
            sent <= 1'b0;
            if (st == S_FETCH) begin
              link_q <= link_in;
              veol_q <= veol_in;
              len_q  <= len_in;
              cnt    <= CW'(XMIT_LAT - 1);
              st     <= S_XMIT;
            end else if (link_in != '0) begin
              ptr <= link_in;
              st  <= S_FETCH;
            end else begin
              st <= S_PARK;
            end
          end
        end
        S_XMIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (link_q != '0 && !veol_q) begin
            ptr <= link_q;
            st  <= S_FETCH;
          end else st <= S_PARK;
        end
        S_PARK: if (kick) st <= S_REFETCH;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> stat_state == 3'd0 && !stat_loaded && !done_valid);
  assert_wr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PARK && ptr_wr && !kick && !stop) |=> stat_ptr == $past(stat_ptr) && stat_wr_err);
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n) stat_wr_err |=> stat_wr_err);
  assert_kick_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XMIT && cnt != '0 && kick && !stop) |=> stat_state == 3'd2);
  assert_stop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> stat_state == 3'd0 && !stat_loaded && stat_ptr == '0);
  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !stop) |=> mem_req_valid && $stable(mem_req_addr));
  assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_hs |=> !mem_req_valid);
endmodule

// File: tb/txq_chain_dma_bench.sv
module txq_chain_dma_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic ptr_wr = 0, kick = 0, stop = 0;
  logic [31:0] ptr_wdata = 0;
  logic [2:0] stat_state;
  logic stat_loaded, stat_wr_err, mem_req_valid, done_valid;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] stat_ptr, mem_req_addr, done_addr;
  logic [63:0] mem_rsp_data = 0;
  logic [11:0] done_len;

  txq_chain_dma u_txq_chain_dma (.*);

  logic [31:0] m_link [16];
  logic [31:0] m_ctl  [16];
  int rsp_lat = 1, rdy_div = 1;
  int nchk = 0, nfail = 0, cyc = 0;
  int dn = 0, hs = 0, viol = 0;
  logic [31:0] dl_addr [64];
  logic [11:0] dl_len  [64];
  logic pend = 0;
  int wcnt = 0, rctr = 0;
  logic [31:0] paddr = 0;

  always @(negedge clk) begin
    mem_rsp_valid = 0;
    if (!rst_n) pend = 0;
    else begin
      if (pend) begin
        if (wcnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = {m_ctl[paddr[6:3]], m_link[paddr[6:3]]};
          pend = 0;
        end else wcnt--;
      end
      rctr++;
      mem_req_ready = (rctr % rdy_div) == 0;
      if (mem_req_valid && mem_req_ready) begin
        if (pend) viol++;
        pend = 1; paddr = mem_req_addr; wcnt = rsp_lat - 1; hs++;
      end
    end
    if (done_valid) begin
      dl_addr[dn % 64] = done_addr; dl_len[dn % 64] = done_len; dn++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nfail++;
      $display("FAIL watchdog R3 actual=%0d expected=<190000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic pulse_kick(); kick = 1; step(); kick = 0; endtask
  task automatic pulse_stop(); stop = 1; step(); stop = 0; endtask
  task automatic write_ptr(input logic [31:0] v); ptr_wr = 1; ptr_wdata = v; step(); ptr_wr = 0; endtask
  task automatic wait_park();
    for (int i = 0; i < 400 && stat_state != 3'd3; i++) step();
  endtask
  task automatic set_desc(input int idx, input logic [31:0] link, input int len, input bit veol);
    m_link[idx] = link; m_ctl[idx] = (32'(len) << 4) | 32'(veol);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) set_desc(i, 0, 0, 0);
    for (int lat = 1; lat <= 3; lat++)
      for (int div = 1; div <= 2; div++)
        for (int n = 1; n <= 4; n++)
          for (int v = 0; v <= 1; v++) begin
            int d0, h0;
            logic [31:0] last;
            rsp_lat = lat; rdy_div = div;
            rst_n = 0; step(); step(); rst_n = 1; step();
            chk("R1 state", 32'(stat_state), 0);
            chk("R1 loaded/err", {30'b0, stat_loaded, stat_wr_err}, 0);
            chk("R1 ptr", stat_ptr, 0);
            chk("R1 req/done", {30'b0, mem_req_valid, done_valid}, 0);
            h0 = hs; pulse_kick(); step();
            chk("R2 kick unloaded", 32'(stat_state), 0);
            chk("R2 no fetch", 32'(hs - h0), 0);
            set_desc(15, 0, 999, 0);
            for (int k = 0; k < n; k++)
              set_desc(k + 1, (k < n - 1) ? 32'(8 * (k + 2)) : (v ? 32'd120 : 32'd0),
                       40 + 3 * k + n, (k == n - 1) && v);
            write_ptr(8);
            chk("R2 ptr loaded", stat_ptr, 8);
            chk("R2 loaded", 32'(stat_loaded), 1);
            d0 = dn; h0 = hs;
            pulse_kick();
            chk("R2 fetch state", 32'(stat_state), 1);
            wait_park();
            chk("R3 done count", 32'(dn - d0), 32'(n));
            chk("R3 fetch count", 32'(hs - h0), 32'(n));
            for (int k = 0; k < n; k++) begin
              chk("R3 done addr", dl_addr[(d0 + k) % 64], 32'(8 * (k + 1)));
              chk("R3 done len", 32'(dl_len[(d0 + k) % 64]), 32'(40 + 3 * k + n));
            end
            last = 32'(8 * n);
            chk("R4 parked", 32'(stat_state), 3);
            chk("R4 held ptr", stat_ptr, last);
            write_ptr(112);
            chk("R5 ptr kept", stat_ptr, last);
            chk("R5 err set", 32'(stat_wr_err), 1);
            set_desc(n, 0, 40 + 3 * (n - 1) + n, 0);
            d0 = dn; h0 = hs;
            pulse_kick(); wait_park();
            chk("R8 no done", 32'(dn - d0), 0);
            chk("R8 one refetch", 32'(hs - h0), 1);
            chk("R8 ptr kept", stat_ptr, last);
            set_desc(10, 88, 200, 0);
            set_desc(11, 0, 201, 0);
            m_link[n] = 80;
            d0 = dn; h0 = hs;
            pulse_kick();
            chk("R7 refetch state", 32'(stat_state), 4);
            for (int i = 0; i < 400 && stat_state != 3'd3; i++) begin
              kick = (stat_state != 3'd3); step();
            end
            kick = 0;
            chk("R6 R7 done count", 32'(dn - d0), 2);
            chk("R6 R7 fetch count", 32'(hs - h0), 3);
            chk("R7 first new", dl_addr[d0 % 64], 80);
            chk("R7 second new", dl_addr[(d0 + 1) % 64], 88);
            chk("R7 held ptr", stat_ptr, 88);
            pulse_stop();
            chk("R9 idle", 32'(stat_state), 0);
            chk("R9 unloaded", {31'b0, stat_loaded}, 0);
            chk("R9 ptr clear", stat_ptr, 0);
            rsp_lat = 5;
            write_ptr(80);
            chk("R9 rewrite", stat_ptr, 80);
            h0 = hs;
            pulse_kick();
            for (int i = 0; i < 50 && hs == h0; i++) step();
            pulse_stop();
            chk("R9 stop in flight", 32'(stat_state), 0);
            rsp_lat = lat;
            write_ptr(88);
            d0 = dn;
            pulse_kick(); wait_park();
            chk("R9 one done", 32'(dn - d0), 1);
            chk("R9 addr", dl_addr[d0 % 64], 88);
            chk("R9 stale dropped", 32'(dl_len[d0 % 64]), 201);
          end
    chk("R10 outstanding", 32'(viol), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule